// File: doc/BRIEF.md
# One-Bit Serial Control Datapath

This block is a single-bit processing unit driven by a 4-bit opcode that arrives each cycle. It works on three one-bit operands: the input bit on the data bus, a result register and a carry register. From these it forms the next result and the next carry. It drives a registered output bit with a write strobe, an 8-line flag bus in which at most one line is high, and a carry-enable line that reports an arithmetic step.

Multi-bit arithmetic runs one bit at a time, least significant bit first, and the carry register holds the carry between bits. Addition uses the plain adder. For two's-complement subtraction, the carry is set to 1 once before the lowest bit, and every bit then uses the complementing adder. With a zero result register and a zero carry, the complementing adder also loads the inverse of the bus bit.

One opcode hands control to a wider command unit outside this block. That handoff appears here only as a one-cycle pulse on a flag line.

Top module: `bitser_cu`

## Requirements
- R1: A synchronous active-high reset, sampled on a falling clock edge, clears the result register, the carry register, `dout_o`, `dwr_o`, `cen_o` and every line of `flag_o`.
- R2: Every register and every output of the block changes only on the falling edge of `clk`. An opcode applied during the high phase has no visible effect at the next rising edge.
- R3: The logic opcodes update the result register from the bus bit `din_i` and the present result. Code 1 loads `din_i`, code 2 loads NOT `din_i`, code 3 computes AND, code 4 computes OR and code 5 computes XOR.
- R4: Code 6 (add) sets the result to the sum bit of result + `din_i` + carry and sets the carry to the carry-out.
- R5: Code 7 (add complement) sets the result to the sum bit of result + NOT `din_i` + carry and sets the carry to the carry-out. With a zero result and a zero carry, it leaves NOT `din_i` in the result and 0 in the carry.
- R6: Code A sets the carry to 1 and code B clears it. Presetting the carry with code A and then applying code 7 to each bit, LSB first, gives the 8-bit two's-complement difference; applying code 6 after a code B gives the 8-bit sum. In both cases the final carry equals the adder carry-out.
- R7: Code 8 drives the result and code 9 drives the inverted result onto `dout_o`. On either code, `dwr_o` is high for that one cycle. On every other code `dwr_o` is low and `dout_o` keeps its last value.
- R8: `flag_o` is decoded one-hot from a 3-bit select, so at most one line is high. Code C raises bit 1, code D raises bit 2, code E (the handoff to the external command unit) raises bit 3 and code F raises bit 4. Each flag lasts one cycle only, and bit 0 is never driven.
- R9: `cen_o` is high for the one cycle that follows codes 6 and 7 and is low otherwise.
- R10: Code 0, the flag codes and the store codes leave the result and carry registers unchanged. The bus bit has no effect on them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 4 | Operation code for this cycle |
| din_i | input | 1 | One-bit data bus input |
| dout_o | output | 1 | Registered data bus output bit |
| dwr_o | output | 1 | Write strobe for `dout_o`, one cycle per store |
| flag_o | output | 8 | One-hot flag lines |
| cen_o | output | 1 | High for the cycle after an arithmetic opcode |

## Verification
Every result of this block is due exactly one falling edge after its opcode is applied, because the opcode, the bus bit and the register contents all meet in the same registered stage. The bench changes its inputs shortly after a falling edge and reads the outputs two nanoseconds after the next falling edge. Each output is therefore compared in the single cycle where that opcode's effect first appears. For R2, the bench also reads the outputs at the rising edge in between and requires them to be unchanged at that point. The result and carry registers have no port of their own, so the bench reads them out with a store opcode, and for the carry an add onto zero first.

// File: rtl/bitser_pkg.sv
package bitser_pkg;

    localparam int OP_W   = 4;
    localparam int FLAG_W = 8;
    localparam int FSEL_W = $clog2(FLAG_W);

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 4'h0,
        OP_LD   = 4'h1,
        OP_LDC  = 4'h2,
        OP_AND  = 4'h3,
        OP_OR   = 4'h4,
        OP_XOR  = 4'h5,
        OP_ADD  = 4'h6,
        OP_ADDC = 4'h7,
        OP_STO  = 4'h8,
        OP_STOC = 4'h9,
        OP_SETC = 4'hA,
        OP_CLRC = 4'hB,
        OP_JMP  = 4'hC,
        OP_RTN  = 4'hD,
        OP_EXT  = 4'hE,
        OP_NOPF = 4'hF
    } op_e;

    typedef enum logic [2:0] {
        AF_HOLD,
        AF_LD,
        AF_LDC,
        AF_AND,
        AF_OR,
        AF_XOR,
        AF_ADD,
        AF_ADDC
    } alu_fn_e;

    typedef enum logic [FSEL_W-1:0] {
        FS_NONE = 'd0,
        FS_JMP  = 'd1,
        FS_RTN  = 'd2,
        FS_EXT  = 'd3,
        FS_NOPF = 'd4
    } fsel_e;

    typedef struct packed {
        alu_fn_e fn;
        logic    arith;
        logic    set_c;
        logic    clr_c;
        logic    store;
        logic    store_inv;
        fsel_e   fsel;
    } ctl_t;

    typedef struct packed {
        logic              res;
        logic              carry;
        logic              dout;
        logic              dwr;
        logic              cen;
        logic [FLAG_W-1:0] flags;
    } state_t;

endpackage

// File: rtl/bitser_decode.sv
module bitser_decode
    import bitser_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output ctl_t            ctl
);
    always_comb begin
        ctl = '{fn: AF_HOLD, arith: 1'b0, set_c: 1'b0, clr_c: 1'b0,
                store: 1'b0, store_inv: 1'b0, fsel: FS_NONE};
        case (op_e'(opcode))
            OP_LD:   ctl.fn = AF_LD;
            OP_LDC:  ctl.fn = AF_LDC;
            OP_AND:  ctl.fn = AF_AND;
            OP_OR:   ctl.fn = AF_OR;
            OP_XOR:  ctl.fn = AF_XOR;
            OP_ADD:  begin ctl.fn = AF_ADD;  ctl.arith = 1'b1; end
            OP_ADDC: begin ctl.fn = AF_ADDC; ctl.arith = 1'b1; end
            OP_STO:  ctl.store = 1'b1;
            OP_STOC: begin ctl.store = 1'b1; ctl.store_inv = 1'b1; end
            OP_SETC: ctl.set_c = 1'b1;
            OP_CLRC: ctl.clr_c = 1'b1;
            OP_JMP:  ctl.fsel = FS_JMP;
            OP_RTN:  ctl.fsel = FS_RTN;
            OP_EXT:  ctl.fsel = FS_EXT;
            OP_NOPF: ctl.fsel = FS_NOPF;
            default: ;
        endcase
    end
endmodule

// File: rtl/bitser_alu.sv
module bitser_alu
    import bitser_pkg::*;
(
    input  alu_fn_e fn,
    input  logic    a,
    input  logic    b,
    input  logic    cin,
    output logic    r,
    output logic    cout
);
    logic [1:0] sum;
    logic       b_eff;

    always_comb begin
        b_eff = (fn == AF_ADDC) ? ~b : b;
        sum   = {1'b0, a} + {1'b0, b_eff} + {1'b0, cin};
        r     = a;
        cout  = cin;
        case (fn)
            AF_LD:   r = b;
            AF_LDC:  r = ~b;
            AF_AND:  r = a & b;
            AF_OR:   r = a | b;
            AF_XOR:  r = a ^ b;
            AF_ADD,
            AF_ADDC: begin
                r    = sum[0];
                cout = sum[1];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bitser_flagdec.sv
module bitser_flagdec #(
    parameter int LINES = 8,
    parameter int SEL_W = $clog2(LINES)
) (
    input  logic [SEL_W-1:0] sel,
    output logic [LINES-1:0] lines
);
    assign lines[0] = 1'b0;
    for (genvar i = 1; i < LINES; i++) begin : g_line
        assign lines[i] = (sel == SEL_W'(i));
    end
endmodule

// File: rtl/bitser_cu.sv
module bitser_cu
    import bitser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   opcode_i,
    input  logic              din_i,
    output logic              dout_o,
    output logic              dwr_o,
    output logic [FLAG_W-1:0] flag_o,
    output logic              cen_o
);
    ctl_t              ctl;
    state_t            st_d, st_q;
    logic              alu_r, alu_c;
    logic [FLAG_W-1:0] flag_dec;

    bitser_decode u_dec (
        .opcode (opcode_i),
        .ctl    (ctl)
    );

    bitser_alu u_alu (
        .fn   (ctl.fn),
        .a    (st_q.res),
        .b    (din_i),
        .cin  (st_q.carry),
        .r    (alu_r),
        .cout (alu_c)
    );

    bitser_flagdec #(.LINES(FLAG_W), .SEL_W(FSEL_W)) u_flg (
        .sel   (ctl.fsel),
        .lines (flag_dec)
    );

    always_comb begin
        st_d       = st_q;
        st_d.res   = alu_r;
        st_d.carry = alu_c;
        if (ctl.set_c) st_d.carry = 1'b1;
        if (ctl.clr_c) st_d.carry = 1'b0;
        st_d.dwr   = ctl.store;
        if (ctl.store) st_d.dout = st_q.res ^ ctl.store_inv;
        st_d.cen   = ctl.arith;
        st_d.flags = flag_dec;
        if (rst) st_d = '0;
    end

    always_ff @(negedge clk) begin
        st_q <= st_d;
    end

    assign dout_o = st_q.dout;
    assign dwr_o  = st_q.dwr;
    assign flag_o = st_q.flags;
    assign cen_o  = st_q.cen;

    AST_FLAGS_ONEHOT: assert property (@(negedge clk) disable iff (rst)
        $onehot0(flag_o) && !flag_o[0]);                                      // R8
    AST_RESET_CLEAR: assert property (@(negedge clk)
        $past(rst) |-> (st_q == '0));                                         // R1
    AST_STROBE_SRC: assert property (@(negedge clk) disable iff (rst)
        dwr_o |-> ($past(opcode_i) == OP_STO || $past(opcode_i) == OP_STOC)); // R7
    AST_DOUT_HOLD: assert property (@(negedge clk) disable iff (rst)
        (!$past(rst) && !dwr_o) |-> $stable(dout_o));                         // R7
    AST_CEN_SRC: assert property (@(negedge clk) disable iff (rst)
        cen_o |-> ($past(opcode_i) == OP_ADD || $past(opcode_i) == OP_ADDC)); // R9
    AST_SETC_ONE: assert property (@(negedge clk) disable iff (rst)
        (!$past(rst) && $past(opcode_i) == OP_SETC) |-> st_q.carry);          // R6
    AST_NOP_KEEP: assert property (@(negedge clk) disable iff (rst)
        (!$past(rst) && $past(opcode_i) == OP_NOP)
            |-> ($stable(st_q.res) && $stable(st_q.carry)));                  // R10
endmodule

// File: tb/sim_bitser_cu.sv
module sim_bitser_cu;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] opcode_i = 4'h0;
    logic       din_i = 1'b0;
    logic       dout_o, dwr_o, cen_o;
    logic [7:0] flag_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    bitser_cu u0 (
        .clk(clk), .rst(rst), .opcode_i(opcode_i), .din_i(din_i),
        .dout_o(dout_o), .dwr_o(dwr_o), .flag_o(flag_o), .cen_o(cen_o)
    );

    typedef struct packed {
        logic [3:0] op;
        logic       din;
        logic       we;
        logic       dout;
        logic [7:0] fl;
        logic       cen;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VT [NV] = '{
        '{4'h1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 4'd3},  // R3 LD 1
        '{4'h8, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 4'd7},  // R7 STO
        '{4'h3, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 4'd3},  // R3 AND 0
        '{4'h8, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 4'd3},
        '{4'h4, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 4'd3},  // R3 OR 1
        '{4'h5, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 4'd3},  // R3 XOR 1 -> 0
        '{4'h9, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 4'd7},  // R7 STOC
        '{4'h2, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 4'd3},  // R3 LDC 0 -> 1
        '{4'h8, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 4'd3},
        '{4'hB, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 4'd6},  // R6 CLRC
        '{4'h6, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 4'd9},  // R9 ADD 1+1+0
        '{4'h8, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 4'd4},  // R4 sum 0
        '{4'h6, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 4'd4},  // R4 0+0+1
        '{4'h8, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 4'd4},
        '{4'h1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 4'd3},
        '{4'h7, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 4'd5},  // R5 0+~1+0
        '{4'h8, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 4'd5},
        '{4'h7, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 4'd5},  // R5 0+~0+0
        '{4'h8, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 4'd5},
        '{4'hC, 1'b0, 1'b0, 1'b1, 8'h02, 1'b0, 4'd8},  // R8 JMP
        '{4'hD, 1'b0, 1'b0, 1'b1, 8'h04, 1'b0, 4'd8},  // R8 RTN
        '{4'hE, 1'b0, 1'b0, 1'b1, 8'h08, 1'b0, 4'd8},  // R8 EXT
        '{4'hF, 1'b0, 1'b0, 1'b1, 8'h10, 1'b0, 4'd8},  // R8 NOPF
        '{4'h9, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 4'd7},  // R7 STOC after flags
        '{4'h0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 4'd10}, // R10 NOP din 0
        '{4'h8, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 4'd10}, // R10 result still 1
        '{4'hA, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 4'd6},  // R6 SETC
        '{4'h1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 4'd3},
        '{4'h6, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 4'd6},  // R6 0+0+1
        '{4'h8, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 4'd6}
    };

    task automatic step(input logic [3:0] op, input logic d);
        opcode_i = op;
        din_i    = d;
        @(negedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [10:0] act, input logic [10:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [10:0] outs(input logic we, input logic d,
                                          input logic [7:0] f, input logic c);
        return {we, d, f, c};
    endfunction

    task automatic serial(input logic sub, input logic [7:0] a, input logic [7:0] b);
        logic [8:0] ref9;
        ref9 = sub ? ({1'b0, a} + {1'b0, ~b} + 9'd1) : ({1'b0, a} + {1'b0, b});
        step(sub ? 4'hA : 4'hB, 1'b0);
        for (int i = 0; i < 8; i++) begin
            step(4'h1, a[i]);
            step(sub ? 4'h7 : 4'h6, b[i]);
            step(4'h8, 1'b0);
            chk(sub ? "R6 serial sub bit" : "R6 serial add bit",
                {10'd0, dout_o}, {10'd0, ref9[i]});
        end
        step(4'h1, 1'b0);
        step(4'h6, 1'b0);
        step(4'h8, 1'b0);
        chk("R6 final carry", {10'd0, dout_o}, {10'd0, ref9[8]});
    endtask

    initial begin
        #1600000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        step(4'h0, 1'b0);
        step(4'h0, 1'b0);
        chk("R1 reset outputs", outs(dwr_o, dout_o, flag_o, cen_o), 11'd0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            step(VT[k].op, VT[k].din);
            n_chk++;
            if (outs(dwr_o, dout_o, flag_o, cen_o) !== outs(VT[k].we, VT[k].dout, VT[k].fl, VT[k].cen)) begin
                n_bad++;
                $display("FAIL R%0d vector %0d actual=%h expected=%h", VT[k].req, k,
                         outs(dwr_o, dout_o, flag_o, cen_o),
                         outs(VT[k].we, VT[k].dout, VT[k].fl, VT[k].cen));
            end
        end

        // R2: a store has no visible effect at the rising edge, only at the falling edge
        step(4'h0, 1'b0);
        opcode_i = 4'h9;
        @(posedge clk);
        #1;
        chk("R2 no change at rising edge", {10'd0, dwr_o}, 11'd0);
        @(negedge clk);
        #2;
        chk("R2 change at falling edge", {10'd0, dwr_o}, 11'd1);

        // R1: reset in the middle of activity wins over an opcode
        step(4'hA, 1'b0);
        step(4'h1, 1'b1);
        rst = 1'b1;
        step(4'hC, 1'b1);
        chk("R1 mid-run reset outputs", outs(dwr_o, dout_o, flag_o, cen_o), 11'd0);
        rst = 1'b0;
        step(4'h8, 1'b0);
        chk("R1 result cleared", {10'd0, dout_o}, 11'd0);
        step(4'h6, 1'b0);
        step(4'h8, 1'b0);
        chk("R1 carry cleared", {10'd0, dout_o}, 11'd0);

        // R5: zero result, zero carry, add complement gives inverted bus bit
        step(4'h1, 1'b0);
        step(4'hB, 1'b0);
        step(4'h7, 1'b1);
        step(4'h8, 1'b0);
        chk("R5 inverse of 1", {10'd0, dout_o}, 11'd0);
        step(4'h6, 1'b0);
        step(4'h8, 1'b0);
        chk("R5 carry stays 0", {10'd0, dout_o}, 11'd0);

        // R7: strobe lasts one cycle
        step(4'h8, 1'b0);
        step(4'h0, 1'b0);
        chk("R7 strobe drops", {10'd0, dwr_o}, 11'd0);

        // R6: 8-bit serial arithmetic, LSB first
        serial(1'b0, 8'h5A, 8'h3C);
        serial(1'b0, 8'hFF, 8'h01);
        serial(1'b1, 8'h5A, 8'h3C);
        serial(1'b1, 8'h10, 8'h20);
        serial(1'b1, 8'h80, 8'h80);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule